// File: doc/BRIEF.md
# Cascadable Offset-Range Binary Counter

A synchronous binary counter built from identical 4-bit stages chained through their carry outputs. Each stage counts only when a shared count-permit input and its own carry-in are both high. The lowest stage's carry-in is the block's carry-enable input, and each higher stage takes the carry-out of the stage below it. A stage's carry-out is high when that stage holds all ones and its carry-in is high. The carry-out of the top stage is the block's carry output. A synchronous clear and a synchronous parallel load act on the whole chain at the next rising edge. Clear wins over load, and load wins over counting.

A two-bit mode input turns the plain counter into one of two offset-range counters. In start-offset mode the carry output reloads a preset start value, so the count runs from that preset up to all ones and then returns to the preset. In end-offset mode a decoded end value clears the count, so the count runs from zero to that end value and then returns to zero. The default configuration is two stages, giving an 8-bit counter. With one stage, a start value of 0110 and an end value of 1101, the block gives the two classic 4-bit offset sequences.

Top module: `offset_cascade_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0 and `carry` is 0.
- R2: With `clear` high, `count` is 0 after the next rising edge, whatever `load`, the enables or the mode are. The end-offset decode acts as a clear and has the same priority.
- R3: With `clear` low and `load` high, `count` takes `loadData` at the next rising edge, whatever `enP` and `enT` are.
- R4: With `clear` and `load` low and no automatic reload or clear, `count` goes up by one (modulo 2^W) at a rising edge only when `enP` and `enT` are both 1. Otherwise `count` holds.
- R5: `carry` is 1 exactly when `enT` is 1 and every bit of `count` is 1. It is combinational.
- R6: In a chain, a stage increments only when all lower stages hold all ones, `enT` is 1 and `enP` is 1. A lower stage wrapping from 1111 to 0000 bumps the stage above it in the same edge.
- R7: With `mode` = 01 (start-offset), `carry` high causes `START_VAL` to be loaded at the next edge. For 4 bits with start value 0110 the sequence is 0110 to 1111, then 0110.
- R8: With `mode` = 10 (end-offset), a `count` equal to `END_VAL` causes a clear at the next edge. For 4 bits with end value 1101 the sequence is 0000 to 1101, then 0000.
- R9: With `mode` = 00 or 11 (plain), no automatic reload or clear occurs, and the count wraps from all ones to zero.
- R10: In start-offset mode, when an external `load` and a carry reload fall in the same cycle, `loadData` is loaded rather than `START_VAL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear to zero |
| load | input | 1 | Synchronous parallel load |
| loadData | input | W | Parallel load value (W = STAGE_W*STAGES) |
| enP | input | 1 | Count permit, shared by all stages |
| enT | input | 1 | Carry enable into the lowest stage; also gates `carry` |
| mode | input | 2 | 00/11 plain, 01 start-offset, 10 end-offset |
| count | output | W | Current count |
| carry | output | 1 | Chain carry-out |

## Verification
The collisions that matter are an explicit clear or load arriving in the same cycle as an automatic action of the offset modes. One case is a clear meeting the end-value decode or a pending load. Another is an external load meeting the carry-triggered reload. These are provoked directly: a load drives the count to all ones or to the end value, and the colliding strobe is applied on the very next cycle. Long random stretches with frequent clears, loads and mode changes then repeat such overlaps. Each cycle's result is judged against an arithmetic next-state model that applies clear, then load, then increment. The model is run for both an 8-bit chain and a single 4-bit stage.

// File: rtl/occ_pkg.sv
package occ_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_START = 2'b01,
    MODE_END   = 2'b10,
    MODE_RSVD  = 2'b11
  } occ_mode_e;

  typedef struct packed {
    logic clr;
    logic ld;
    logic cntP;
  } occ_strobe_t;
endpackage

// File: rtl/occ_ctrl.sv
module occ_ctrl
  import occ_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter int unsigned START_VAL = 6,
  parameter int unsigned END_VAL   = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        load,
  input  logic [W-1:0] loadData,
  input  logic        enP,
  input  occ_mode_e   modeSel,
  input  logic [W-1:0] count,
  input  logic        carry,
  output occ_strobe_t strobe,
  output logic [W-1:0] loadVal
);
  localparam logic [W-1:0] START_V = W'(START_VAL);
  localparam logic [W-1:0] END_V   = W'(END_VAL);

  logic autoClr;
  logic autoLd;

  always_comb begin
    autoClr     = (modeSel == MODE_END)   && (count == END_V);
    autoLd      = (modeSel == MODE_START) && carry;
    strobe.clr  = clear | autoClr;
    strobe.ld   = load | autoLd;
    strobe.cntP = enP;
    loadVal     = load ? loadData : START_V;
  end

  // R8: reaching the end value in end-offset mode returns the count to zero
  p_end_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (modeSel == MODE_END && count == END_V) |=> (count == '0));

  // R7: carry in start-offset mode without outside strobes reloads the preset
  p_start_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (modeSel == MODE_START && carry && !clear && !load) |=> (count == START_V));

  // R10: an outside load beats the carry reload
  p_load_over_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (modeSel == MODE_START && carry && !clear && load) |=> (count == $past(loadData)));
endmodule

// File: rtl/occ_dp.sv
module occ_dp
  import occ_pkg::*;
#(
  parameter int unsigned STAGE_W = 4,
  parameter int unsigned STAGES  = 2,
  localparam int unsigned W      = STAGE_W * STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  occ_strobe_t  strobe,
  input  logic [W-1:0] loadVal,
  input  logic         enT,
  output logic [W-1:0] count,
  output logic         carry
);
  logic [STAGE_W-1:0] stageQ [STAGES];
  logic [STAGES:0]    tChain;

  assign tChain[0] = enT;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    assign tChain[i+1]              = tChain[i] & (&stageQ[i]);
    assign count[i*STAGE_W +: STAGE_W] = stageQ[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        stageQ[i] <= '0;
      else if (strobe.clr)               stageQ[i] <= '0;
      else if (strobe.ld)                stageQ[i] <= loadVal[i*STAGE_W +: STAGE_W];
      else if (strobe.cntP && tChain[i]) stageQ[i] <= stageQ[i] + STAGE_W'(1);
    end
  end

  assign carry = tChain[STAGES];

  // R2: a clear strobe zeroes every stage
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clr |=> (count == '0));

  // R3: a load strobe without clear takes the presented value
  p_load_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.ld && !strobe.clr) |=> (count == $past(loadVal)));

  // R4 / R6: both enables give one step of the whole chain
  p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.clr && !strobe.ld && strobe.cntP && enT) |=> (count == $past(count) + W'(1)));

  // R4: a missing enable holds the count
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.clr && !strobe.ld && !(strobe.cntP && enT)) |=> $stable(count));

  // R5: carry only with all ones and the carry enable
  p_carry_cond_r5: assert property (@(posedge clk) disable iff (!rst_n)
    carry |-> (enT && (&count)));
endmodule

// File: rtl/offset_cascade_counter.sv
module offset_cascade_counter
  import occ_pkg::*;
#(
  parameter int unsigned STAGE_W   = 4,
  parameter int unsigned STAGES    = 2,
  parameter int unsigned START_VAL = 6,
  parameter int unsigned END_VAL   = 13,
  localparam int unsigned W        = STAGE_W * STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] loadData,
  input  logic         enP,
  input  logic         enT,
  input  logic [1:0]   mode,
  output logic [W-1:0] count,
  output logic         carry
);
  occ_strobe_t  strobe;
  logic [W-1:0] loadVal;
  occ_mode_e    modeSel;

  assign modeSel = occ_mode_e'(mode);

  occ_ctrl #(.W(W), .START_VAL(START_VAL), .END_VAL(END_VAL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load(load), .loadData(loadData),
    .enP(enP), .modeSel(modeSel), .count(count), .carry(carry),
    .strobe(strobe), .loadVal(loadVal)
  );

  occ_dp #(.STAGE_W(STAGE_W), .STAGES(STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .loadVal(loadVal), .enT(enT),
    .count(count), .carry(carry)
  );

  // R1: nothing leaves reset with a carry pending on a zero count
  p_reset_zero_r1: assert property (@(posedge clk) $rose(rst_n) |-> (count == '0));
endmodule

// File: tb/offset_cascade_counter_tb.sv
module offset_cascade_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0, load = 1'b0, enP = 1'b0, enT = 1'b0;
  logic [7:0] loadData = '0;
  logic [1:0] mode = 2'b00;
  logic [7:0] count8;
  logic [3:0] count4;
  logic       carry8, carry4;

  int nChecks = 0;
  int nFail   = 0;
  int e8 = 0;
  int e4 = 0;
  int cycles = 0;

  localparam int W_START = 48;
  localparam int W_END   = 200;

  always #10 clk = ~clk;

  offset_cascade_counter #(.STAGES(2), .START_VAL(W_START), .END_VAL(W_END)) u_dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load(load), .loadData(loadData),
    .enP(enP), .enT(enT), .mode(mode), .count(count8), .carry(carry8)
  );

  offset_cascade_counter #(.STAGES(1), .START_VAL(6), .END_VAL(13)) u_dut_nib (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load(load), .loadData(loadData[3:0]),
    .enP(enP), .enT(enT), .mode(mode), .count(count4), .carry(carry4)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit cyOf(input int q, input int w, input bit t);
    return t && (q == (1 << w) - 1);
  endfunction

  // clear first, then load (outside data over preset), then increment
  function automatic int nxt(input int q, input int w, input bit c, input bit l,
                             input int d, input bit p, input bit t, input int md,
                             input int sv, input int ev);
    int m = (1 << w) - 1;
    bit aClr = c || (md == 2 && q == ev);
    bit aLd  = l || (md == 1 && cyOf(q, w, t));
    if (aClr)       return 0;
    if (aLd)        return l ? (d & m) : sv;
    if (p && t)     return (q + 1) & m;
    return q;
  endfunction

  task automatic step(input bit c, input bit l, input int d, input bit p, input bit t,
                      input int md, input string tag);
    int n8, n4;
    clear = c; load = l; loadData = d[7:0]; enP = p; enT = t; mode = md[1:0];
    #2;
    chk("R5 carry wide", int'(carry8), int'(cyOf(e8, 8, t)));
    chk("R5 carry nib",  int'(carry4), int'(cyOf(e4, 4, t)));
    n8 = nxt(e8, 8, c, l, d, p, t, md, W_START, W_END);
    n4 = nxt(e4, 4, c, l, d, p, t, md, 6, 13);
    @(posedge clk);
    #2;
    chk({tag, " wide"}, int'(count8), n8);
    chk({tag, " nib"},  int'(count4), n4);
    e8 = n8;
    e4 = n4;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nFail++;
        nChecks++;
        $display("FAIL watchdog: actual=%0d expected<150000", cycles);
        $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset wide", int'(count8), 0);
    chk("R1 reset nib",  int'(count4), 0);
    chk("R1 reset carry", int'(carry8 | carry4), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // plain full sweep: every value of both widths, wrap and cascade
    for (int i = 0; i < 300; i++) step(0, 0, 0, 1, 1, 0, "R4 R6 R9 plain sweep");
    // enable combinations at each point
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < 8; i++) step(0, 0, 0, k[0], k[1], 0, "R4 enable pattern");
    // cascade boundary: low stage at 1111 with T off, then on
    step(0, 1, 8'h0F, 0, 0, 0, "R3 load");
    step(0, 0, 0, 1, 0, 3, "R6 no T hold");
    step(0, 0, 0, 1, 1, 3, "R6 low wrap bumps high");
    // load every value, ignoring enables
    for (int v = 0; v < 256; v++) step(0, 1, v, v[0], v[1], 0, "R3 load sweep");
    // clear against load and count
    step(0, 1, 8'h55, 1, 1, 0, "R3 load");
    step(1, 1, 8'hAA, 1, 1, 0, "R2 clear over load");
    step(0, 1, W_END, 1, 1, 0, "R3 load end value");
    step(0, 1, 9, 1, 1, 2, "R2 R8 decode clear over load");
    // start-offset sequences
    for (int i = 0; i < 300; i++) step(0, 0, 0, 1, 1, 1, "R7 start-offset run");
    step(0, 1, 8'hFF, 1, 1, 0, "R3 load ones");
    step(0, 0, 0, 1, 0, 1, "R7 no reload without T");
    step(0, 1, 3, 1, 1, 1, "R10 load beats reload");
    // end-offset sequences
    step(1, 0, 0, 1, 1, 0, "R2 clear");
    for (int i = 0; i < 300; i++) step(0, 0, 0, 1, 1, 2, "R8 end-offset run");
    // random collisions
    for (int i = 0; i < 4000; i++)
      step(($urandom % 16) == 0, ($urandom % 8) == 0, int'($urandom % 256),
           ($urandom % 4) != 0, ($urandom % 4) != 0, int'($urandom % 4),
           "R2 R3 R4 R7 R8 R10 random");

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule